// File: doc/BRIEF.md
# Multichannel Conversion Scan Controller

This block decides which of up to eight analog channels is converted next and collects the results. A control write carries a channel enable mask, a burst flag and a start flag. With burst clear and start set, the lowest enabled channel is converted once. With burst set, the block steps through every enabled channel from the lowest upward and wraps around for as long as burst stays set.

The controller does not convert anything itself. It hands each conversion to an external sequencer through a start pulse and a channel number. It waits for that sequencer's completion pulse and stores the result in a data register. The data register holds the sample, its channel number, a done flag and an overrun flag. A read strobe tells the block that software has consumed the register. The interrupt request mirrors the done flag.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Mask bit i enables channel i. A control write with start set and burst clear launches exactly one conversion, on the lowest enabled channel.
- R2: A mask of all zeros behaves as if only channel 0 were enabled.
- R3: In burst mode the launches visit the enabled channels in ascending order and wrap back to the lowest. The step from the highest channel back to the lowest takes the same single cycle as any other step.
- R4: A control write with both burst and start clear launches nothing. If a conversion is in flight, that conversion runs to completion and is captured, and no further launch follows.
- R5: On an accepted completion the data register takes the sample and the channel it came from, and done goes to 1. The interrupt request equals done. After reset, done, overrun, the interrupt request and the sequencer start are all 0.
- R6: A read strobe clears done and overrun. If a completion is captured in the same cycle as a read, done ends up 1 and overrun ends up 0.
- R7: Overrun becomes 1 when a burst-mode result is captured while the previous result is still unread (done is 1 and no read arrives in that cycle). A capture in single mode leaves overrun at 0.
- R8: Every control write clears done and overrun, unless a completion is captured in the same cycle.
- R9: A control write with start or burst set, arriving while a conversion is in flight, discards that conversion. The block relaunches in the next cycle using the new mask, so only the result of the new conversion is ever stored.
- R10: The sequencer start is a one-cycle pulse that carries its channel number. The block accepts a completion pulse only while a launched conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_mask_i | input | NUM_CH | Channel enable mask carried by the write |
| ctrl_burst_i | input | 1 | Burst flag carried by the write |
| ctrl_start_i | input | 1 | Start-now flag carried by the write |
| rd_i | input | 1 | Data register read strobe |
| conv_start_o | output | 1 | Launch pulse to the conversion sequencer |
| conv_ch_o | output | $clog2(NUM_CH) | Channel for the launched conversion |
| conv_done_i | input | 1 | Completion pulse from the sequencer |
| conv_res_i | input | RES_W | Sample delivered with the completion pulse |
| data_res_o | output | RES_W | Stored sample |
| data_ch_o | output | $clog2(NUM_CH) | Channel of the stored sample |
| data_ovr_o | output | 1 | Overrun flag |
| data_done_o | output | 1 | Done flag |
| irq_o | output | 1 | Interrupt request, high while done is 1 |

## Verification
The capture of a new sample and the read of the old one can fall in the same cycle. That cycle decides whether a result was lost, so it sets the value of overrun.

The bench provokes the collision with its sequencer model during a single-channel burst. The model raises the read strobe in exactly the cycle in which it delivers a completion. The outcome is judged at the ports: done must stay 1 and overrun must read 0. The next unread capture must then set overrun, which shows that the flag was cleared by the collision and not simply never set.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } scan_state_e;

endpackage

// File: rtl/adc_scan_pick.sv
// Channel picker: effective mask, lowest enabled channel, next enabled above cur_i (wrapping).
module adc_scan_pick #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] mask_i,
  input  logic [W-1:0] cur_i,
  output logic [N-1:0] eff_o,
  output logic [W-1:0] first_o,
  output logic [W-1:0] next_o
);

  assign eff_o = (|mask_i) ? mask_i : N'(1);

  always_comb begin
    first_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eff_o[i]) first_o = W'(i);
    end
  end

  // Descending scan leaves the lowest enabled index above cur_i; none found keeps first_o.
  always_comb begin
    next_o = first_o;
    for (int i = N - 1; i >= 0; i--) begin
      if (eff_o[i] && (W'(i) > cur_i)) next_o = W'(i);
    end
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [NUM_CH-1:0] ctrl_mask_i,
  input  logic              ctrl_burst_i,
  input  logic              ctrl_start_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic              cap_o,
  output logic              cap_burst_o
);

  scan_state_e       state_q, state_d;
  logic              burst_q, burst_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [CH_W-1:0]   ch_q, ch_d;

  logic [NUM_CH-1:0] pick_mask, pick_eff;
  logic [CH_W-1:0]   pick_first, pick_next;
  logic              go;
  logic              burst_now;

  // On a write pick from the new mask, otherwise from the stored one.
  assign pick_mask = ctrl_wr_i ? ctrl_mask_i : mask_q;

  adc_scan_pick #(
    .N (NUM_CH),
    .W (CH_W)
  ) i_pick (
    .mask_i  (pick_mask),
    .cur_i   (ch_q),
    .eff_o   (pick_eff),
    .first_o (pick_first),
    .next_o  (pick_next)
  );

  assign go        = ctrl_wr_i && (ctrl_burst_i || ctrl_start_i);
  assign burst_now = ctrl_wr_i ? ctrl_burst_i : burst_q;

  always_comb begin
    state_d = state_q;
    burst_d = burst_q;
    mask_d  = mask_q;
    ch_d    = ch_q;
    cap_o   = 1'b0;

    unique case (state_q)
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done_i) begin
          cap_o = 1'b1;
          if (burst_now) begin
            ch_d    = pick_next;
            state_d = ST_LAUNCH;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = state_q;
    endcase

    if (ctrl_wr_i) begin
      mask_d  = pick_eff;
      burst_d = ctrl_burst_i;
    end

    // A launching write abandons whatever is in flight.
    if (go) begin
      cap_o   = 1'b0;
      ch_d    = pick_first;
      state_d = ST_LAUNCH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      mask_q  <= NUM_CH'(1);
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      burst_q <= burst_d;
      mask_q  <= mask_d;
      ch_q    <= ch_d;
    end
  end

  assign conv_start_o = (state_q == ST_LAUNCH);
  assign conv_ch_o    = ch_q;
  assign cap_burst_o  = burst_q;

  p_start_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> mask_q[conv_ch_o]);

  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && !ctrl_wr_i) |=> !conv_start_o);

  p_stop_no_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && conv_done_i && !burst_q && !ctrl_wr_i) |=> !conv_start_o);

endmodule

// File: rtl/adc_scan_result.sv
module adc_scan_result #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             cap_burst_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [RES_W-1:0] res_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             done_o,
  output logic             ovr_o
);

  logic done_d, ovr_d;

  always_comb begin
    if (cap_i)              done_d = 1'b1;
    else if (clr_i || rd_i) done_d = 1'b0;
    else                    done_d = done_o;

    if (clr_i)      ovr_d = 1'b0;
    else if (cap_i) ovr_d = cap_burst_i && !rd_i && (ovr_o || done_o);
    else if (rd_i)  ovr_d = 1'b0;
    else            ovr_d = ovr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      ch_o   <= '0;
      done_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (cap_i) begin
        res_o <= res_i;
        ch_o  <= ch_i;
      end
      done_o <= done_d;
      ovr_o  <= ovr_d;
    end
  end

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cap_i) |=> (!done_o && !ovr_o));

  p_clash_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && rd_i) |=> (done_o && !ovr_o));

  p_ovr_needs_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> done_o);

  p_single_no_ovr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !cap_burst_i) |=> !ovr_o);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 10,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [NUM_CH-1:0] ctrl_mask_i,
  input  logic              ctrl_burst_i,
  input  logic              ctrl_start_i,
  input  logic              rd_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_res_i,
  output logic [RES_W-1:0]  data_res_o,
  output logic [CH_W-1:0]   data_ch_o,
  output logic              data_ovr_o,
  output logic              data_done_o,
  output logic              irq_o
);

  logic cap, cap_burst;

  adc_scan_fsm #(
    .NUM_CH (NUM_CH)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_mask_i  (ctrl_mask_i),
    .ctrl_burst_i (ctrl_burst_i),
    .ctrl_start_i (ctrl_start_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .cap_o        (cap),
    .cap_burst_o  (cap_burst)
  );

  adc_scan_result #(
    .RES_W (RES_W),
    .CH_W  (CH_W)
  ) i_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .cap_burst_i (cap_burst),
    .res_i       (conv_res_i),
    .ch_i        (conv_ch_o),
    .rd_i        (rd_i),
    .clr_i       (ctrl_wr_i),
    .res_o       (data_res_o),
    .ch_o        (data_ch_o),
    .done_o      (data_done_o),
    .ovr_o       (data_ovr_o)
  );

  assign irq_o = data_done_o;

endmodule

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_mask = 8'h00;
  logic       ctrl_burst = 1'b0;
  logic       ctrl_start = 1'b0;
  logic       rd_task = 1'b0;
  logic       rd_resp = 1'b0;
  logic       rd;
  logic       conv_done = 1'b0;
  logic [9:0] conv_res = '0;
  logic       conv_start_o;
  logic [2:0] conv_ch_o;
  logic [9:0] data_res_o;
  logic [2:0] data_ch_o;
  logic       data_ovr_o, data_done_o, irq_o;

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;

  // sequencer model state
  int         lat = 4;
  int         cnt = 0;
  int         nl = 0;
  logic [2:0] cur_ch = '0;
  int         log_ch [0:255];
  logic [9:0] last_res = '0;
  bit         rd_clash = 1'b0;

  assign rd = rd_task | rd_resp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_scan_ctrl i_adc_scan_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_wr_i    (ctrl_wr),
    .ctrl_mask_i  (ctrl_mask),
    .ctrl_burst_i (ctrl_burst),
    .ctrl_start_i (ctrl_start),
    .rd_i         (rd),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .conv_done_i  (conv_done),
    .conv_res_i   (conv_res),
    .data_res_o   (data_res_o),
    .data_ch_o    (data_ch_o),
    .data_ovr_o   (data_ovr_o),
    .data_done_o  (data_done_o),
    .irq_o        (irq_o)
  );

  // Sequencer model: a new launch restarts the countdown; completion after lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      rd_resp   = 1'b0;
      if (!rst_n) begin
        cnt = 0;
      end else if (conv_start_o) begin
        cnt    = lat;
        cur_ch = conv_ch_o;
        if (nl < 256) log_ch[nl] = int'(conv_ch_o);
        nl++;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          conv_done = 1'b1;
          conv_res  = {cur_ch, 7'(nl)};
          last_res  = conv_res;
          if (rd_clash) begin
            rd_resp  = 1'b1;
            rd_clash = 1'b0;
          end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] m, input logic b, input logic s);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_mask = m; ctrl_burst = b; ctrl_start = s;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_burst = 1'b0; ctrl_start = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_task = 1'b1;
    @(negedge clk);
    rd_task = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !data_done_o; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    check("R5 reset done", int'(data_done_o), 0);
    check("R5 reset ovr", int'(data_ovr_o), 0);
    check("R5 reset irq", int'(irq_o), 0);
    check("R10 reset start", int'(conv_start_o), 0);
  endtask

  task automatic test_single();
    int nb;
    lat = 4;
    nb = nl;
    write_ctrl(8'h2C, 1'b0, 1'b1);
    check("R1 launch", int'(conv_start_o), 1);
    check("R1 lowest channel", int'(conv_ch_o), 2);
    @(negedge clk);
    check("R10 one-cycle start", int'(conv_start_o), 0);
    wait_done();
    check("R5 done", int'(data_done_o), 1);
    check("R5 channel", int'(data_ch_o), 2);
    check("R5 sample", int'(data_res_o), int'(last_res));
    check("R5 irq", int'(irq_o), 1);
    check("R7 single no ovr", int'(data_ovr_o), 0);
    repeat (10) @(negedge clk);
    check("R1 single launch count", nl - nb, 1);
    do_read();
    check("R6 read clears done", int'(data_done_o), 0);
    check("R6 read clears irq", int'(irq_o), 0);
  endtask

  task automatic test_zero_mask();
    write_ctrl(8'h00, 1'b0, 1'b1);
    check("R2 zero mask launch", int'(conv_start_o), 1);
    check("R2 zero mask ch0", int'(conv_ch_o), 0);
    wait_done();
    check("R2 stored channel", int'(data_ch_o), 0);
    do_read();
  endtask

  task automatic test_no_go();
    int nb;
    nb = nl;
    write_ctrl(8'hFF, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check("R4 no-go write launches nothing", nl - nb, 0);
    check("R4 no-go done stays 0", int'(data_done_o), 0);
  endtask

  task automatic test_burst();
    int nb, nb2;
    int exp_seq [5] = '{1, 5, 7, 1, 5};
    lat = 4;
    nb = nl;
    write_ctrl(8'hA2, 1'b1, 1'b0);
    for (int i = 0; i < 200 && nl < nb + 5; i++) @(negedge clk);
    for (int k = 0; k < 5; k++) check("R3 scan order", log_ch[nb + k], exp_seq[k]);
    check("R7 overrun set", int'(data_ovr_o), 1);
    check("R7 done with overrun", int'(data_done_o), 1);
    write_ctrl(8'hA2, 1'b0, 1'b0);
    check("R8 write clears done", int'(data_done_o), 0);
    check("R8 write clears ovr", int'(data_ovr_o), 0);
    wait_done();
    check("R4 in-flight completes", int'(data_done_o), 1);
    check("R4 in-flight channel", int'(data_ch_o), 5);
    check("R4 in-flight sample", int'(data_res_o), int'(last_res));
    nb2 = nl;
    repeat (20) @(negedge clk);
    check("R4 no launch after stop", nl - nb2, 0);
    do_read();
  endtask

  task automatic test_clash();
    lat = 4;
    write_ctrl(8'h08, 1'b1, 1'b0);
    wait_done();
    rd_clash = 1'b1;
    for (int i = 0; i < 100 && rd_clash; i++) @(negedge clk);
    @(negedge clk);
    check("R6 clash done stays", int'(data_done_o), 1);
    check("R6 clash ovr cleared", int'(data_ovr_o), 0);
    check("R6 clash channel", int'(data_ch_o), 3);
    repeat (12) @(negedge clk);
    check("R7 ovr after unread capture", int'(data_ovr_o), 1);
    write_ctrl(8'h08, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    do_read();
    check("R6 final read", int'(data_done_o), 0);
  endtask

  task automatic test_restart();
    int nb;
    lat = 10;
    nb = nl;
    write_ctrl(8'h40, 1'b0, 1'b1);
    check("R9 first launch ch6", int'(conv_ch_o), 6);
    repeat (3) @(negedge clk);
    write_ctrl(8'h10, 1'b0, 1'b1);
    check("R9 relaunch", int'(conv_start_o), 1);
    check("R9 relaunch ch4", int'(conv_ch_o), 4);
    wait_done();
    check("R9 stored channel", int'(data_ch_o), 4);
    check("R9 stored sample", int'(data_res_o), int'(last_res));
    repeat (15) @(negedge clk);
    check("R9 launch count", nl - nb, 2);
    check("R9 no overrun", int'(data_ovr_o), 0);
    write_ctrl(8'h10, 1'b0, 1'b0);
    check("R8 write clears done", int'(data_done_o), 0);
    check("R8 write clears irq", int'(irq_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single();
    test_zero_mask();
    test_no_go();
    test_burst();
    test_clash();
    test_restart();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule